// File: doc/BRIEF.md
# Non-Overlapping Pulse Pattern Generator

This block drives an 8-bit output pattern from a staged pattern register. An internal 16-bit up-counter paces the updates. When the counter reaches the period value it returns to zero, and an update begins.

An update runs in two steps. At the period match, only the bits that must go from 1 to 0 change. A programmable number of cycles later, at the margin match, the bits that must go from 0 to 1 follow. Between the two steps the output is the bitwise AND of the old and new patterns. This keeps complementary phase outputs from ever being high together.

The margin match also sets a request flag. The host answers the flag by staging the next pattern and clearing the flag. The eight outputs form two 4-bit groups, each with its own enable and its own two-step/one-step select.

A sequencer with three states governs the update:

- **ST_IDLE**: the counter is stopped.
- **ST_FALL_WAIT**: the sequencer waits for the period match.
- **ST_RISE_WAIT**: the falling bits have been applied and the sequencer waits for the margin match.

It has these transitions:

- **start**: ST_IDLE to ST_FALL_WAIT, when the run bit is set.
- **fall**: ST_FALL_WAIT to ST_RISE_WAIT, at a period match.
- **rise**: ST_RISE_WAIT to ST_FALL_WAIT, at a margin match.
- **late**: ST_RISE_WAIT to ST_RISE_WAIT, at a period match that arrives with no margin match before it.
- **stop**: any state to ST_IDLE, when the run bit is cleared.

Top module: `npo_pulse_gen`

## Requirements
- R1: While the run bit (control bit 4) is 1, the counter steps 0,1,…,P and then returns to 0, where P is the period register (address 0). Pattern updates therefore start every P+1 cycles. The output changes in the cycle after the counter reaches P, and not one cycle earlier.
- R2: The output changes only in the cycle after a period match or a margin match. Register writes by themselves never change it.
- R3: At a period match, in a group whose control bit 2 (low group, bits 3:0) or bit 3 (high group, bits 7:4) is 1, each enabled bit that is 1 and staged as 0 goes to 0. All other bits hold, so the output becomes old AND new. Example: 0x95 to 0x65 gives 0x05.
- R4: At a margin match, which comes M+1 cycles after the period match, where M is the margin register (address 1), the bits that are 0 and staged as 1 go to 1. The output then equals the staged pattern (address 2, bits 7:0). No bit falls at a margin match.
- R5: Staging 0x95, 0x65, 0x59, 0x56, 0x95 in turn gives the output sequence 95, 05, 65, 41, 59, 50, 56, 14, 95.
- R6: A group whose enable bit is 0 (control bit 0 for the low group, bit 1 for the high group) holds its output through both match events.
- R7: An enabled group with its two-step bit at 0 takes the whole staged value at the period match and holds at the margin match.
- R8: When M ≥ P, no margin match occurs and the flag is not set. The output passes through old AND new at one period match. At the next period match it takes the full staged value.
- R9: A margin match sets the request flag in the following cycle. Writing 1 to bit 0 at address 4 clears it. Writing 0 there leaves it set.
- R10: After reset the output is 0x00 and the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 period, 1 margin, 2 staged pattern, 3 control, 4 flag clear |
| wr_data | input | 16 | Register write data |
| pulse_out | output | 8 | Pattern output |
| req_flag | output | 1 | Request flag, set by a margin match |

## Verification
Suppose the sequencer state goes wrong: it misses the fall transition or takes the rise transition out of turn. The intermediate AND pattern then never appears, or a rising bit shows up at the period match. Either fault is visible on `pulse_out` one cycle after that match.

A counter that is off by a cycle moves every later update by the same amount. The bench checks the output on the exact cycle before and after each expected change, so such an error shows within one period.

A wrong flag state appears on `req_flag` at the margin match, or at the clear write that follows it.

// File: rtl/npo_pkg.sv
package npo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FALL_WAIT = 2'd1,
        ST_RISE_WAIT = 2'd2
    } npo_state_e;

    localparam int NPO_ADDR_PERIOD = 0;
    localparam int NPO_ADDR_MARGIN = 1;
    localparam int NPO_ADDR_STAGE  = 2;
    localparam int NPO_ADDR_CTRL   = 3;
    localparam int NPO_ADDR_CLEAR  = 4;

endpackage

// File: rtl/npo_regs.sv
module npo_regs
    import npo_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int OUT_W  = 8,
    parameter int N_GRP  = 2,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmp_a,
    output logic [CNT_W-1:0]  period_q,
    output logic [CNT_W-1:0]  margin_q,
    output logic [OUT_W-1:0]  stage_q,
    output logic [N_GRP-1:0]  grp_en_q,
    output logic [N_GRP-1:0]  grp_nov_q,
    output logic              run_q,
    output logic              flag_q
);

    localparam int RUN_BIT = 2 * N_GRP;

    logic sel_period, sel_margin, sel_stage, sel_ctrl, sel_clear;

    assign sel_period = wr_en && (wr_addr == ADDR_W'(NPO_ADDR_PERIOD));
    assign sel_margin = wr_en && (wr_addr == ADDR_W'(NPO_ADDR_MARGIN));
    assign sel_stage  = wr_en && (wr_addr == ADDR_W'(NPO_ADDR_STAGE));
    assign sel_ctrl   = wr_en && (wr_addr == ADDR_W'(NPO_ADDR_CTRL));
    assign sel_clear  = wr_en && (wr_addr == ADDR_W'(NPO_ADDR_CLEAR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q  <= '1;
            margin_q  <= '0;
            stage_q   <= '0;
            grp_en_q  <= '0;
            grp_nov_q <= '0;
            run_q     <= 1'b0;
        end else begin
            if (sel_period) period_q <= wr_data[CNT_W-1:0];
            if (sel_margin) margin_q <= wr_data[CNT_W-1:0];
            if (sel_stage)  stage_q  <= wr_data[OUT_W-1:0];
            if (sel_ctrl) begin
                grp_en_q  <= wr_data[N_GRP-1:0];
                grp_nov_q <= wr_data[2*N_GRP-1:N_GRP];
                run_q     <= wr_data[RUN_BIT];
            end
        end
    end

    // Request flag: a margin match sets it; a write of 1 clears it; set wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (cmp_a) begin
            flag_q <= 1'b1;
        end else if (sel_clear && wr_data[0]) begin
            flag_q <= 1'b0;
        end
    end

    // R9: a margin match is always followed by a raised flag
    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_a |=> flag_q);

    // R9: a clear write of zero never drops the flag
    p_flag_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && sel_clear && !wr_data[0]) |=> flag_q);

endmodule

// File: rtl/npo_timebase.sv
module npo_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] margin,
    output logic             cmp_a,
    output logic             cmp_b
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             margin_ok;

    assign margin_ok = (margin < period);
    assign cmp_b     = run && (cnt_q == period);
    assign cmp_a     = run && margin_ok && (cnt_q == margin);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cmp_b) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // R1: the counter restarts from zero after a period match
    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_b |=> (cnt_q == '0));

    // R8: the two match events never coincide
    p_events_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_a && cmp_b));

endmodule

// File: rtl/npo_seq.sv
module npo_seq
    import npo_pkg::*;
#(
    parameter int GRP_W = 4,
    parameter int N_GRP = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   cmp_a,
    input  logic                   cmp_b,
    input  logic [GRP_W*N_GRP-1:0] stage,
    input  logic [N_GRP-1:0]       grp_en,
    input  logic [N_GRP-1:0]       grp_nov,
    output logic [GRP_W*N_GRP-1:0] pulse_q
);

    localparam int OUT_W = GRP_W * N_GRP;

    npo_state_e       state_q, state_d;
    logic [OUT_W-1:0] en_bits, nov_bits, cand, pulse_d;

    for (genvar g = 0; g < N_GRP; g++) begin : g_mask
        assign en_bits[g*GRP_W +: GRP_W]  = {GRP_W{grp_en[g]}};
        assign nov_bits[g*GRP_W +: GRP_W] = {GRP_W{grp_nov[g]}};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, fall, rise, late, stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (run)        state_d = ST_FALL_WAIT;
            ST_FALL_WAIT: if (!run)       state_d = ST_IDLE;
                          else if (cmp_b) state_d = ST_RISE_WAIT;
            ST_RISE_WAIT: if (!run)       state_d = ST_IDLE;
                          else if (cmp_a) state_d = ST_FALL_WAIT;
                          else if (cmp_b) state_d = ST_RISE_WAIT;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // output candidate per state, then masked by group enables
    always_comb begin
        cand = pulse_q;
        unique case (state_q)
            ST_IDLE: cand = pulse_q;
            ST_FALL_WAIT: begin
                if (cmp_b) cand = (nov_bits & pulse_q & stage) | (~nov_bits & stage);
            end
            ST_RISE_WAIT: begin
                if (cmp_b)      cand = stage;
                else if (cmp_a) cand = (nov_bits & (pulse_q | stage)) | (~nov_bits & pulse_q);
            end
            default: cand = pulse_q;
        endcase
        pulse_d = (cand & en_bits) | (pulse_q & ~en_bits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    // R3: no two-step bit rises at the period match
    p_no_rise_at_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_b && state_q == ST_FALL_WAIT) |=>
        ((pulse_q & ~$past(pulse_q) & $past(nov_bits & en_bits)) == '0));

    // R4: no bit falls at the margin match
    p_rise_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a && state_q == ST_RISE_WAIT) |=> ((~pulse_q & $past(pulse_q)) == '0));

    // R6: disabled groups never move
    p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((pulse_q ^ $past(pulse_q)) & ~$past(en_bits)) == '0));

    // R2: without a match event the output is stable
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_a || cmp_b) |=> $stable(pulse_q));

endmodule

// File: rtl/npo_pulse_gen.sv
module npo_pulse_gen
    import npo_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GRP_W  = 4,
    parameter int N_GRP  = 2,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [GRP_W*N_GRP-1:0] pulse_out,
    output logic                   req_flag
);

    localparam int OUT_W = GRP_W * N_GRP;

    logic [CNT_W-1:0] period, margin;
    logic [OUT_W-1:0] stage;
    logic [N_GRP-1:0] grp_en, grp_nov;
    logic             run, cmp_a, cmp_b;

    npo_regs #(
        .CNT_W(CNT_W), .OUT_W(OUT_W), .N_GRP(N_GRP),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_a(cmp_a),
        .period_q(period), .margin_q(margin), .stage_q(stage),
        .grp_en_q(grp_en), .grp_nov_q(grp_nov), .run_q(run),
        .flag_q(req_flag)
    );

    npo_timebase #(.CNT_W(CNT_W)) u_time (
        .clk(clk), .rst_n(rst_n), .run(run),
        .period(period), .margin(margin),
        .cmp_a(cmp_a), .cmp_b(cmp_b)
    );

    npo_seq #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cmp_a(cmp_a), .cmp_b(cmp_b),
        .stage(stage), .grp_en(grp_en), .grp_nov(grp_nov),
        .pulse_q(pulse_out)
    );

endmodule

// File: tb/test_npo_pulse_gen.sv
module test_npo_pulse_gen;

    localparam int CLK_P = 10;

    // {staged, after period match, after margin match}
    localparam logic [23:0] VEC [5] = '{
        24'h95_00_95, 24'h65_05_65, 24'h59_41_59, 24'h56_50_56, 24'h95_14_95
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  pulse_out;
    logic        req_flag;

    int unsigned cyc = 0;
    int unsigned base = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    npo_pulse_gen i_npo_pulse_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pulse_out(pulse_out), .req_flag(req_flag)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc - base);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic at_edge(input int unsigned n);
        while (cyc < base + n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 5000);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset output", {8'h0, pulse_out}, 16'h00);
        chk("R10 reset flag", {15'h0, req_flag}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        wr(3'd0, 16'd9);
        wr(3'd1, 16'd3);
        wr(3'd2, 16'h0095);
        chk("R2 writes leave output", {8'h0, pulse_out}, 16'h00);
        wr(3'd3, 16'h001F);
        base = cyc;

        // table walk: four-phase rotation (R1 R3 R4 R5 R9)
        for (int i = 0; i < 5; i++) begin
            int unsigned eb;
            eb = 10 + 10 * i;
            at_edge(eb - 1);
            chk("R1 no change before period match", {8'h0, pulse_out},
                (i == 0) ? 16'h00 : {8'h0, VEC[i-1][7:0]});
            at_edge(eb);
            chk("R3/R5 falling step", {8'h0, pulse_out}, {8'h0, VEC[i][15:8]});
            at_edge(eb + 3);
            chk("R2 AND held in margin", {8'h0, pulse_out}, {8'h0, VEC[i][15:8]});
            if (i > 0) chk("R9 flag cleared before match", {15'h0, req_flag}, 16'h0);
            at_edge(eb + 4);
            chk("R4/R5 rising step", {8'h0, pulse_out}, {8'h0, VEC[i][7:0]});
            chk("R9 flag set", {15'h0, req_flag}, 16'h1);
            wr(3'd4, 16'h0001);
            if (i < 4) wr(3'd2, {8'h0, VEC[i+1][23:16]});
        end

        // R6: high group disabled
        at_edge(56);
        wr(3'd3, 16'h001D);
        wr(3'd2, 16'h006A);
        at_edge(60);
        chk("R6 disabled group holds at fall", {8'h0, pulse_out}, 16'h90);
        at_edge(64);
        chk("R6 disabled group holds at rise", {8'h0, pulse_out}, 16'h9A);

        // R7: low group one-step
        wr(3'd3, 16'h001B);
        wr(3'd2, 16'h0035);
        at_edge(70);
        chk("R7 one-step group at period match", {8'h0, pulse_out}, 16'h15);
        at_edge(74);
        chk("R7 one-step group holds at margin", {8'h0, pulse_out}, 16'h35);

        // R8 and R9 clear behaviour
        wr(3'd1, 16'd12);
        wr(3'd3, 16'h001F);
        wr(3'd2, 16'h00C3);
        wr(3'd4, 16'h0000);
        chk("R9 zero write keeps flag", {15'h0, req_flag}, 16'h1);
        wr(3'd4, 16'h0001);
        chk("R9 one write clears flag", {15'h0, req_flag}, 16'h0);
        at_edge(80);
        chk("R8 falling step with big margin", {8'h0, pulse_out}, 16'h01);
        at_edge(84);
        chk("R8 no margin match", {8'h0, pulse_out}, 16'h01);
        chk("R8 flag stays clear", {15'h0, req_flag}, 16'h0);
        at_edge(90);
        chk("R8 late rise at next period match", {8'h0, pulse_out}, 16'hC3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule